// File: doc/BRIEF.md
# Configurable Single-Wire Bus Slot Generator

This block produces the bus master's bit-level time slots on a single-wire open-drain bus: write-1, write-0 and read. The host asks for a slot with a one-cycle start pulse and the bit to send. A read uses the same waveform as a write-1. When the slot ends, the block returns the bus level it sampled. Slot timing comes from an internal prescaler that divides the clock down to a one-microsecond tick. Each slot is timed in whole microseconds from the cycle in which the start pulse is accepted.

The slot is made of coded segments. In flexible-standard mode, a 3-bit low-time code sets the length of the low pulse in write-1 and read slots. A second 3-bit code sets the time from the end of that pulse to the sampling point. The same code also sets the recovery time that follows the long low phase of a write-0 slot. The high time and the write-0 low phase are fixed. In overdrive mode, every segment has a short fixed value and the codes are not used. A third 3-bit code holds a pulldown edge-rate setting. The block only stores this code and drives it out to the analog pad driver.

Codes can be written at any time. The block copies them, together with the speed input and the bit value, at the moment a slot starts. A write made during a slot therefore reshapes only the following slot.

Top module: `swire_slot_gen`

## Requirements
- R1: After reset, bus_drive_low, sample_stb, done, rd_bit and busy are 0 and slew_code is 000. The stored low-time code is 000 and the stored offset code is 011, so a flexible write-1 slot after reset is 8 µs low, samples at 14 µs and lasts 63 µs.
- R2: A start pulse is accepted only while busy is 0. An accepted start raises busy on the next cycle. A start pulse seen while busy is 1 has no effect on the slot in progress.
- R3: A flexible-mode slot with bit_val=1 drives the bus low for 8+L µs, where L is the low-time code. It then releases the bus for 3+D µs (D is the offset code) plus a fixed 49 µs, for a total length of 60 to 74 µs.
- R4: A flexible-mode slot with bit_val=0 drives the bus low for 57 µs and then releases it for a recovery time of 3+D µs, for a total length of 60 to 67 µs.
- R5: With od_mode=1 at the start, the fixed overdrive values apply. A write-1/read slot is 1 µs low, samples 1 µs later and is 10 µs long. A write-0 slot is 7 µs low and 10 µs long.
- R6: In write-1/read slots only, sample_stb is high for exactly one cycle. That cycle is the first cycle of microsecond (low time + offset) of the slot. sample_stb never goes high in a write-0 slot.
- R7: rd_bit is cleared at slot start. It takes the value of bus_in during the sample_stb cycle and keeps that value until the next slot starts. A write-0 slot returns 0.
- R8: done is a one-cycle pulse in the cycle right after the last cycle of the slot. busy is 0 in that same cycle, and a new start can be accepted in that cycle.
- R9: A write with cfg_we=1 selects its target with cfg_sel: 0 = low-time code, 1 = offset code, 2 = slew code, 3 = no register. The slew code appears on slew_code on the next cycle.
- R10: A code write made while a slot is in progress, or in the same cycle as an accepted start, does not change the current slot. It takes effect from the next slot onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Code register write enable |
| cfg_sel | input | 2 | Write target: 0 low-time, 1 offset/recovery, 2 slew, 3 none |
| cfg_data | input | CODE_W | Code value to write |
| od_mode | input | 1 | 1 selects overdrive timing for the slot being started |
| start | input | 1 | Slot request, accepted while idle |
| bit_val | input | 1 | 1 for write-1/read slot, 0 for write-0 slot |
| bus_in | input | 1 | Sensed bus level |
| bus_drive_low | output | 1 | Enables the open-drain pulldown |
| sample_stb | output | 1 | Marks the cycle in which the bus is sampled |
| done | output | 1 | One-cycle slot completion pulse |
| rd_bit | output | 1 | Sampled bit of the last slot |
| busy | output | 1 | Slot in progress |
| slew_code | output | CODE_W | Stored pulldown edge-rate code |

## Verification
The checker verifies several local rules on every cycle:
- done is a single-cycle pulse with busy low and the pulldown released;
- busy only rises after a start;
- the pulldown only begins right after a start;
- the sample strobe falls inside a busy slot after the low phase;
- the slew code changes only after a write.

The exact segment lengths for each code and mode cannot be seen by these local rules. Neither can the returned bit, the isolation of the current slot from writes made during it, or the rejection of a start while busy. Those come from the bench's scenarios compared cycle by cycle against its timing model.

// File: rtl/swire_slot_gen.sv
module swire_slot_gen #(
  parameter int TICKS_PER_US = 200,
  parameter int CODE_W = 3,
  parameter int US_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CODE_W-1:0] cfg_data,
  input  logic              od_mode,
  input  logic              start,
  input  logic              bit_val,
  input  logic              bus_in,
  output logic              bus_drive_low,
  output logic              sample_stb,
  output logic              done,
  output logic              rd_bit,
  output logic              busy,
  output logic [CODE_W-1:0] slew_code
);

  localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_US - 1);

  localparam logic [US_W-1:0] FX_LOW1_BASE = US_W'(8);
  localparam logic [US_W-1:0] FX_OFS_BASE  = US_W'(3);
  localparam logic [US_W-1:0] FX_HIGH      = US_W'(49);
  localparam logic [US_W-1:0] FX_LOW0      = US_W'(57);
  localparam logic [US_W-1:0] OD_LOW1      = US_W'(1);
  localparam logic [US_W-1:0] OD_OFS       = US_W'(1);
  localparam logic [US_W-1:0] OD_HIGH      = US_W'(8);
  localparam logic [US_W-1:0] OD_LOW0      = US_W'(7);
  localparam logic [US_W-1:0] OD_REC       = US_W'(3);
  localparam logic [CODE_W-1:0] RST_OFS_CODE = CODE_W'(3);

  logic [CODE_W-1:0] low_code, ofs_code, slew_q;
  logic [CODE_W-1:0] lc_q, oc_q;
  logic              od_q, one_q;
  logic [PW-1:0]     pre;
  logic [US_W-1:0]   us_cnt;
  logic              busy_q, done_q, rd_q;

  logic [US_W-1:0] low1_us, ofs_us, high_us, low0_us, rec_us;
  logic [US_W-1:0] low_len, samp_at, slot_len;
  logic            tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_code <= '0;
      ofs_code <= RST_OFS_CODE;
      slew_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    low_code <= cfg_data;
        2'd1:    ofs_code <= cfg_data;
        2'd2:    slew_q   <= cfg_data;
        default: ;
      endcase
    end
  end

  assign low1_us = od_q ? OD_LOW1 : FX_LOW1_BASE + US_W'(lc_q);
  assign ofs_us  = od_q ? OD_OFS  : FX_OFS_BASE + US_W'(oc_q);
  assign high_us = od_q ? OD_HIGH : FX_HIGH;
  assign low0_us = od_q ? OD_LOW0 : FX_LOW0;
  assign rec_us  = od_q ? OD_REC  : FX_OFS_BASE + US_W'(oc_q);

  assign low_len  = one_q ? low1_us : low0_us;
  assign samp_at  = low1_us + ofs_us;
  assign slot_len = one_q ? samp_at + high_us : low0_us + rec_us;

  assign tick = (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      pre    <= '0;
      us_cnt <= '0;
      od_q   <= 1'b0;
      one_q  <= 1'b0;
      lc_q   <= '0;
      oc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          pre    <= '0;
          us_cnt <= '0;
          od_q   <= od_mode;
          one_q  <= bit_val;
          lc_q   <= low_code;
          oc_q   <= ofs_code;
          rd_q   <= 1'b0;
        end
      end else begin
        if (sample_stb) rd_q <= bus_in;
        if (tick) begin
          pre <= '0;
          if (us_cnt == slot_len - US_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            us_cnt <= us_cnt + US_W'(1);
          end
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end

  assign bus_drive_low = busy_q && (us_cnt < low_len);
  assign sample_stb    = busy_q && one_q && (us_cnt == samp_at) && (pre == '0);
  assign done          = done_q;
  assign rd_bit        = rd_q;
  assign busy          = busy_q;
  assign slew_code     = slew_q;

endmodule

// File: rtl/swire_slot_gen_chk.sv
module swire_slot_gen_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              start,
  input logic              bus_drive_low,
  input logic              sample_stb,
  input logic              done,
  input logic              busy,
  input logic [CODE_W-1:0] slew_code
);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_drive_low));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_drive_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !bus_drive_low);

  assert_sample_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (busy && !bus_drive_low));

  assert_sample_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_slew_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(slew_code));

endmodule

bind swire_slot_gen swire_slot_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .start(start),
  .bus_drive_low(bus_drive_low), .sample_stb(sample_stb), .done(done),
  .busy(busy), .slew_code(slew_code)
);

// File: tb/swire_slot_gen_tb.sv
`timescale 1ns/1ps
module swire_slot_gen_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [2:0] cfg_data = 3'd0;
  logic od_mode = 1'b0, start = 1'b0, bit_val = 1'b0, answer = 1'b1;
  logic bus_in;
  logic bus_drive_low, sample_stb, done, rd_bit, busy;
  logic [2:0] slew_code;

  always #2.5 clk = ~clk;

  assign bus_in = ~bus_drive_low & answer;

  swire_slot_gen #(.TICKS_PER_US(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .od_mode(od_mode), .start(start), .bit_val(bit_val), .bus_in(bus_in),
    .bus_drive_low(bus_drive_low), .sample_stb(sample_stb), .done(done),
    .rd_bit(rd_bit), .busy(busy), .slew_code(slew_code)
  );

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  bit m_busy, m_is1, m_rd, m_done;
  int m_t, m_low, m_samp, m_len, m_lc, m_oc, m_sc;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_is1 = 0; m_rd = 0; m_done = 0; m_t = 0;
      m_low = 0; m_samp = 0; m_len = 0; m_lc = 0; m_oc = 3; m_sc = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_is1 && m_t == m_samp * DIV) m_rd = bus_in;
        if (m_t == m_len * DIV - 1) begin m_busy = 0; m_done = 1; end
        else m_t++;
      end else if (start) begin
        int l1, of, hi, l0, rc;
        if (od_mode) begin l1 = 1; of = 1; hi = 8; l0 = 7; rc = 3; end
        else begin l1 = 8 + m_lc; of = 3 + m_oc; hi = 49; l0 = 57; rc = 3 + m_oc; end
        m_busy = 1; m_t = 0; m_is1 = bit_val; m_rd = 0;
        m_samp = l1 + of;
        m_low  = bit_val ? l1 : l0;
        m_len  = bit_val ? l1 + of + hi : l0 + rc;
      end
      if (cfg_we) begin
        if (cfg_sel == 2'd0) m_lc = int'(cfg_data);
        else if (cfg_sel == 2'd1) m_oc = int'(cfg_data);
        else if (cfg_sel == 2'd2) m_sc = int'(cfg_data);
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp("busy R2",          busy, m_busy);
    cmp("bus_drive_low R3", bus_drive_low, m_busy && m_t < m_low * DIV);
    cmp("sample_stb R6",    sample_stb, m_busy && m_is1 && m_t == m_samp * DIV);
    cmp("rd_bit R7",        rd_bit, m_rd);
    cmp("done R8",          done, m_done);
    cmp("slew_code R9",     slew_code, m_sc);
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic wr(input logic [1:0] sel, input logic [2:0] val);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_data = val;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic slot(input string req, input logic one, input logic od, input logic ans);
    cur_req = req;
    @(negedge clk); start = 1; bit_val = one; od_mode = od; answer = ans;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    slot("R1", 1, 0, 0);
    slot("R4", 0, 0, 1);
    slot("R7", 1, 0, 1);
    wr(2'd0, 3'd7); wr(2'd1, 3'd6);
    slot("R3", 1, 0, 1);
    wr(2'd0, 3'd0); wr(2'd1, 3'd7);
    slot("R3", 1, 0, 0);
    slot("R4", 0, 0, 0);
    cur_req = "R2";
    @(negedge clk); start = 1; bit_val = 0; od_mode = 0;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    start = 1; bit_val = 1; od_mode = 1;
    @(negedge clk); start = 0;
    cur_req = "R10";
    cfg_we = 1; cfg_sel = 2'd1; cfg_data = 3'd0;
    @(negedge clk); cfg_we = 0;
    while (!done) @(negedge clk);
    slot("R10", 0, 0, 1);
    @(negedge clk); start = 1; bit_val = 1; od_mode = 0; answer = 0;
    cfg_we = 1; cfg_sel = 2'd0; cfg_data = 3'd5;
    @(negedge clk); start = 0; cfg_we = 0;
    while (!done) @(negedge clk);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    slot("R5", 1, 1, 0);
    slot("R5", 1, 1, 1);
    slot("R5", 0, 1, 0);
    cur_req = "R8";
    @(negedge clk); start = 1; bit_val = 0; od_mode = 1;
    @(negedge clk);
    while (!done) @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    cur_req = "R9";
    wr(2'd2, 3'd5);
    wr(2'd3, 3'd2);
    slot("R9", 1, 1, 1);
    wr(2'd2, 3'd0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule